// File: doc/BRIEF.md
# Write Completion Status Read Multiplexer

This block sits on the read path of a nonvolatile memory controller and picks the byte returned on each read strobe. When no internal write is running, a read of the array returns the array byte. A read of the small register space returns one of three things: a manufacturer or device identification constant, the live state of five general-purpose input pins, or zero for an unused offset.

While an internal program or erase is in progress, every read returns an end-of-write status byte instead, whatever its target. Bit 7 of that byte is a polling bit, and its meaning depends on the operation kind. Bit 6 is a toggle bit that alternates on each successive read strobe. The toggle bit is not tied to the clock, so host software that reads twice sees a change only while the write is still running.

The block is told three things by the write engine: whether an operation is running, whether that operation is an erase, and bit 7 of the byte being programmed. The output is registered and changes only on the clock edge that samples a strobe.

Top module: `wsr_read_mux`

## Requirements
- R1: After reset, rd_data reads 00h.
- R2: With busy low, a strobe with rd_is_reg low returns arr_data as sampled with the strobe.
- R3: With busy low, a register read at offset 0 returns BFh and at offset 1 returns 51h.
- R4: With busy low, a register read at offset 4 returns the gpi pins in bits 4:0 and zero in bits 7:5.
- R5: With busy low, a register read at offsets 2, 3, 5, 6 and 7 returns 00h.
- R6: While busy is high and op_erase is low (program), bit 7 of each read equals the complement of prog_msb, and bits 5:0 read zero.
- R7: While busy is high and op_erase is high (erase), bit 7 of each read is 0 and bits 5:0 read zero.
- R8: While busy is high, bit 6 is 0 on the first read after busy rises, including a read in the rising cycle itself, and it inverts on each further read strobe. Clock cycles without a strobe leave it unchanged.
- R9: While busy is high, a register read returns the status byte of R6/R7/R8 and not the register contents.
- R10: rd_data changes only on the clock edge that samples rd_strobe high, one cycle after the strobe is presented, and holds at every other edge.
- R11: Once busy falls, reads return the true array data again, and repeated reads of the same byte return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | 1 = running operation is an erase, 0 = program |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| rd_strobe | input | 1 | One-cycle read request |
| rd_is_reg | input | 1 | 1 = register space, 0 = array |
| rd_addr | input | ADDR_W | Register offset |
| arr_data | input | DATA_W | Array read data |
| gpi | input | GPI_W | General-purpose input pins |
| rd_data | output | DATA_W | Returned read byte |

## Verification
If the toggle flip-flop holds a wrong value, it shows at the ports on the very first status read after busy rises, because bit 6 of that read is expected to be 0. A toggle that advances per clock rather than per strobe shows within one read pair once idle cycles are placed between reads. A wrong busy-time selection shows one cycle after any strobe as a bit 7 that does not match the operation kind, or as nonzero low bits. A stuck busy path shows on the first array read after completion.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

   typedef enum logic {
      OPK_PROGRAM = 1'b0,
      OPK_ERASE   = 1'b1
   } wsr_op_e;

   // Status word: polling bit at the top, toggle bit just below, rest zero.
   function automatic logic [7:0] wsr_status8(input wsr_op_e kind,
                                              input logic    msb,
                                              input logic    tog);
      logic poll;
      poll = (kind == OPK_ERASE) ? 1'b0 : ~msb;
      return {poll, tog, 6'b000000};
   endfunction

endpackage

// File: rtl/wsr_toggle.sv
module wsr_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic rd_strobe,
   output logic start,
   output logic tog_now
);

   logic busy_q;
   logic tog_q;

   assign start   = busy & ~busy_q;
   assign tog_now = start ? 1'b0 : tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         tog_q  <= 1'b0;
      end else begin
         busy_q <= busy;
         if (busy && rd_strobe) begin
            tog_q <= ~tog_now;
         end else if (start) begin
            tog_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/wsr_regs.sv
module wsr_regs #(
   parameter int          DATA_W  = 8,
   parameter int          ADDR_W  = 3,
   parameter int          GPI_W   = 5,
   parameter int          GPI_OFS = 4,
   parameter logic [7:0]  MFR_ID  = 8'hBF,
   parameter logic [7:0]  DEV_ID  = 8'h51
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [GPI_W-1:0]  gpi,
   output logic [DATA_W-1:0] rdata
);

   localparam int PAD_W = DATA_W - GPI_W;

   logic [DATA_W-1:0] gpi_word;
   logic [DATA_W-1:0] mfr_word;
   logic [DATA_W-1:0] dev_word;

   generate
      if (PAD_W > 0) begin : g_pad
         assign gpi_word = {{PAD_W{1'b0}}, gpi};
      end else begin : g_nopad
         assign gpi_word = gpi;
      end
      if (DATA_W > 8) begin : g_idwide
         assign mfr_word = {{(DATA_W-8){1'b0}}, MFR_ID};
         assign dev_word = {{(DATA_W-8){1'b0}}, DEV_ID};
      end else begin : g_idnarrow
         assign mfr_word = MFR_ID;
         assign dev_word = DEV_ID;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(0)) begin
         rdata = mfr_word;
      end else if (addr == ADDR_W'(1)) begin
         rdata = dev_word;
      end else if (addr == ADDR_W'(GPI_OFS)) begin
         rdata = gpi_word;
      end
   end

endmodule

// File: rtl/wsr_status.sv
module wsr_status
   import wsr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              op_erase,
   input  logic              prog_msb,
   input  logic              tog,
   output logic [DATA_W-1:0] status
);

   logic [7:0] core8;
   wsr_op_e    kind;

   assign kind  = op_erase ? OPK_ERASE : OPK_PROGRAM;
   assign core8 = wsr_status8(kind, prog_msb, tog);

   generate
      if (DATA_W > 8) begin : g_wide
         // Status bits stay at the two top positions of the word.
         assign status = {core8[7:6], {(DATA_W-2){1'b0}}};
      end else begin : g_byte
         assign status = core8;
      end
   endgenerate

endmodule

// File: rtl/wsr_read_mux.sv
module wsr_read_mux #(
   parameter int          DATA_W  = 8,
   parameter int          ADDR_W  = 3,
   parameter int          GPI_W   = 5,
   parameter int          GPI_OFS = 4,
   parameter logic [7:0]  MFR_ID  = 8'hBF,
   parameter logic [7:0]  DEV_ID  = 8'h51,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              op_erase,
   input  logic              prog_msb,
   input  logic              rd_strobe,
   input  logic              rd_is_reg,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] arr_data,
   input  logic [GPI_W-1:0]  gpi,
   output logic [DATA_W-1:0] rd_data
);

   localparam int REG_SLOTS = 1 << ADDR_W;

   generate
      if (DATA_W < 8) begin : g_chk_dw
         $error("DATA_W must be at least 8");
      end
      if (GPI_W < 1 || GPI_W > DATA_W - 2) begin : g_chk_gpi
         $error("GPI_W must leave the two status bits free");
      end
      if (GPI_OFS < 2 || GPI_OFS >= REG_SLOTS) begin : g_chk_ofs
         $error("GPI_OFS must lie past the ID slots and inside the register space");
      end
   endgenerate

   logic              start;
   logic              tog_now;
   logic [DATA_W-1:0] reg_word;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] sel_word;

   wsr_toggle u_tog (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .rd_strobe (rd_strobe),
      .start     (start),
      .tog_now   (tog_now)
   );

   wsr_regs #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .GPI_W   (GPI_W),
      .GPI_OFS (GPI_OFS),
      .MFR_ID  (MFR_ID),
      .DEV_ID  (DEV_ID)
   ) u_regs (
      .addr  (rd_addr),
      .gpi   (gpi),
      .rdata (reg_word)
   );

   wsr_status #(.DATA_W(DATA_W)) u_stat (
      .op_erase (op_erase),
      .prog_msb (prog_msb),
      .tog      (tog_now),
      .status   (stat_word)
   );

   always_comb begin
      if (busy) begin
         sel_word = stat_word;
      end else if (rd_is_reg) begin
         sel_word = reg_word;
      end else begin
         sel_word = arr_data;
      end
   end

   generate
      if (OUT_REG) begin : g_oreg
         logic [DATA_W-1:0] out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_q <= '0;
            end else if (rd_strobe) begin
               out_q <= sel_word;
            end
         end
         assign rd_data = out_q;
      end else begin : g_ocomb
         assign rd_data = sel_word;
      end
   endgenerate

endmodule

// File: rtl/wsr_read_mux_chk.sv
module wsr_read_mux_chk #(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 3,
   parameter int GPI_W   = 5,
   parameter int GPI_OFS = 4,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              op_erase,
   input logic              prog_msb,
   input logic              rd_strobe,
   input logic              rd_is_reg,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] arr_data,
   input logic [GPI_W-1:0]  gpi,
   input logic [DATA_W-1:0] rd_data
);

   generate
      if (OUT_REG) begin : g_props
         // R10: no strobe, no change
         a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_strobe |=> $stable(rd_data));

         // R2: idle array read passes the array byte
         a_r2_array: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_strobe && !busy && !rd_is_reg) |=> rd_data == $past(arr_data));

         // R4: GPI register is zero-padded live pins
         a_r4_gpi: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_strobe && !busy && rd_is_reg && rd_addr == ADDR_W'(GPI_OFS))
            |=> rd_data == DATA_W'($past(gpi)));

         // R6: program polling bit is the inverted data bit
         a_r6_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_strobe && busy && !op_erase)
            |=> (rd_data[DATA_W-1] == !$past(prog_msb)) && (rd_data[DATA_W-3:0] == '0));

         // R7: erase polling bit is zero
         a_r7_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_strobe && busy && op_erase)
            |=> !rd_data[DATA_W-1] && (rd_data[DATA_W-3:0] == '0));

         // R8: first read in the rising cycle of busy sees toggle 0
         a_r8_first_tog: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(busy) && rd_strobe) |=> !rd_data[DATA_W-2]);
      end
   endgenerate

endmodule

bind wsr_read_mux wsr_read_mux_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .GPI_W   (GPI_W),
   .GPI_OFS (GPI_OFS),
   .OUT_REG (OUT_REG)
) u_chk (.*);

// File: tb/sim_wsr_read_mux.sv
`timescale 1ns/1ps
module sim_wsr_read_mux;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       busy = 1'b0;
   logic       op_erase = 1'b0;
   logic       prog_msb = 1'b0;
   logic       rd_strobe = 1'b0;
   logic       rd_is_reg = 1'b0;
   logic [2:0] rd_addr = '0;
   logic [7:0] arr_data = '0;
   logic [4:0] gpi = '0;
   logic [7:0] rd_data;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   logic exp_t = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wsr_read_mux u0 (
      .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
      .prog_msb(prog_msb), .rd_strobe(rd_strobe), .rd_is_reg(rd_is_reg),
      .rd_addr(rd_addr), .arr_data(arr_data), .gpi(gpi), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   // Present a strobe for one cycle; returns after the capturing edge.
   task automatic rd(input logic is_reg, input logic [2:0] a);
      @(negedge clk);
      rd_is_reg = is_reg;
      rd_addr   = a;
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   function automatic logic [7:0] reg_exp(input logic [2:0] a, input logic [4:0] g);
      case (a)
         3'd0: return 8'hBF;
         3'd1: return 8'h51;
         3'd4: return {3'b000, g};
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] stat_exp(input logic er, input logic msb, input logic t);
      return {(er ? 1'b0 : ~msb), t, 6'b0};
   endfunction

   task automatic begin_op(input logic er, input logic msb);
      @(negedge clk);
      busy = 1'b1; op_erase = er; prog_msb = msb;
      exp_t = 1'b0;
   endtask

   task automatic end_op();
      @(negedge clk);
      busy = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", rd_data, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", rd_data, 8'h00);

      // R2: array sweep
      for (int v = 0; v < 256; v++) begin
         arr_data = 8'(v);
         rd(1'b0, 3'd0);
         check("R2", rd_data, 8'(v));
      end

      // R3 R4 R5: register sweep over all offsets and gpi values
      for (int g = 0; g < 32; g++) begin
         for (int a = 0; a < 8; a++) begin
            gpi = 5'(g);
            arr_data = 8'hA5;
            rd(1'b1, 3'(a));
            if (a < 2)       check("R3", rd_data, reg_exp(3'(a), 5'(g)));
            else if (a == 4) check("R4", rd_data, reg_exp(3'(a), 5'(g)));
            else             check("R5", rd_data, reg_exp(3'(a), 5'(g)));
         end
      end

      // R10: output holds without a strobe
      arr_data = 8'h3C;
      rd(1'b0, 3'd0);
      arr_data = 8'hC3;
      repeat (4) @(negedge clk);
      check("R10", rd_data, 8'h3C);

      // R6 R8 R9: program with every MSB value, reads spread over idle cycles
      for (int k = 0; k < 2; k++) begin
         begin_op(1'b0, 1'(k));
         for (int r = 0; r < 5; r++) begin
            repeat (r) @(negedge clk);
            arr_data = 8'(8'h5A + r);
            rd(r[0], 3'(r));
            check(r[0] ? "R9" : "R6", rd_data, stat_exp(1'b0, 1'(k), exp_t));
            check("R8", {7'b0, rd_data[6]}, {7'b0, exp_t});
            exp_t = ~exp_t;
         end
         end_op();
         // R11: true data returns, stable across repeated reads
         arr_data = 8'h7E;
         rd(1'b0, 3'd0);
         check("R11", rd_data, 8'h7E);
         rd(1'b0, 3'd0);
         check("R11", rd_data, 8'h7E);
      end

      // R7 R9: erase, register and array reads
      begin_op(1'b1, 1'b1);
      for (int r = 0; r < 4; r++) begin
         rd(r[1], 3'd4);
         check(r[1] ? "R9" : "R7", rd_data, stat_exp(1'b1, 1'b0, exp_t));
         exp_t = ~exp_t;
      end
      end_op();
      arr_data = 8'hFF;
      rd(1'b0, 3'd0);
      check("R11", rd_data, 8'hFF);

      // R8: strobe in the same cycle busy rises; toggle restarts at 0
      @(negedge clk);
      busy = 1'b1; op_erase = 1'b0; prog_msb = 1'b0;
      rd_is_reg = 1'b0; rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      check("R8", rd_data, 8'h80);
      repeat (3) @(negedge clk);
      check("R10", rd_data, 8'h80);
      rd(1'b0, 3'd0);
      check("R8", rd_data, 8'hC0);
      end_op();

      // R8: back-to-back strobes
      begin_op(1'b1, 1'b0);
      @(negedge clk);
      rd_strobe = 1'b1;
      for (int r = 0; r < 4; r++) begin
         @(negedge clk);
         check("R8", rd_data, stat_exp(1'b1, 1'b0, exp_t));
         exp_t = ~exp_t;
      end
      rd_strobe = 1'b0;
      end_op();

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule